// File: doc/BRIEF.md
# Variable-length instruction decoder

This block decodes one instruction of a small 32-bit register-machine instruction set. Each cycle it receives a window of six bytes that begins at the current program counter, together with the program counter itself and a flag that reports a failed instruction fetch. It returns the fields of the instruction that begins at byte 0 of the window: instruction code, function code, two register identifiers, a 32-bit constant, the instruction length, the address of the following instruction and a status code. A stop flag marks any status other than normal operation.

The decode path is combinational and feeds one output register stage. Results therefore appear one clock after the inputs are sampled. The only state is that output register, which has two named conditions. In RESET it holds fixed values while `rst_n` is low. In DECODE it reloads on every rising edge. The single transition, RESET to DECODE, happens on the first edge after `rst_n` goes high. The instruction length depends only on the high nibble of byte 0. A fixed format map gives the length, whether a register byte is present, and where the constant sits. The block does not fetch bytes, read registers, execute instructions or touch data memory.

Top module: `vli_decoder`

## Requirements
- R1: While reset is active, every output is zero except `stat_o`, which reads 1 (normal).
- R2: `icode_o` is the high nibble of byte 0 and `ifun_o` is its low nibble. Byte i of the window is `win_i[8*i+7:8*i]`.
- R3: The length depends on the instruction code. Codes 0, 1 and 9 give 1 byte. Codes 2, 6, A and B give 2 bytes. Codes 7 and 8 give 5 bytes. Codes 3, 4 and 5 give 6 bytes.
- R4: Codes 2, 3, 4, 5, 6, A and B carry a register byte at byte 1. For these, `ra_o` is its high nibble and `rb_o` is its low nibble. Every other code reports 0xF (no register) in both fields.
- R5: The constant is little-endian. Codes 7 and 8 take it from bytes 1 to 4. Codes 3, 4 and 5 take it from bytes 2 to 5. Every other code gives 0. For example, bytes 30 82 cd ab 00 00 give code 3, rA 8, rB 2 and constant 0x0000abcd.
- R6: When the status is 1 or 2, `valp_o` equals the sampled PC plus the length, modulo 2^32.
- R7: The legal function codes are 0 to 3 for code 6, and 0 to 6 for codes 2 and 7. Every other code from 0 to B requires function code 0. Any other pair gives status 4 (invalid).
- R8: Instruction codes C to F always give status 4.
- R9: A legal halt (byte 0 = 0x00) gives status 2, and `stop_o` is high.
- R10: When the fetch-error flag is set, the status is 3 (bad address), and this overrides statuses 4 and 2.
- R11: `stop_o` is high exactly when the status is not 1.
- R12: Outputs change only on a rising clock edge. Each result reflects the inputs sampled at the previous edge, so every cycle carries one independent decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Address of byte 0 of the window |
| win_i | input | 48 | Instruction bytes; byte i in bits 8*i+7..8*i |
| imem_err_i | input | 1 | Instruction fetch failed for this window |
| icode_o | output | 4 | Instruction code |
| ifun_o | output | 4 | Function code |
| ra_o | output | 4 | First register ID, 0xF when absent |
| rb_o | output | 4 | Second register ID, 0xF when absent |
| valc_o | output | 32 | Constant or absolute destination |
| len_o | output | 3 | Instruction length in bytes |
| valp_o | output | 32 | PC plus length |
| stat_o | output | 3 | 1 normal, 2 halt, 3 bad address, 4 invalid |
| stop_o | output | 1 | Status is not normal |

## Verification
The output register holds only one decode, so any internal fault shows at the ports on the very next edge. A wrong format-map entry gives a wrong length and next PC for that opcode. A wrong constant offset gives a byte-shifted value. A wrong priority shows an invalid or halt status where a bad address was expected. The scoreboard compares every cycle's result, so a fault stays confined to the vector that triggers it. No value is carried into later cycles that could hide it or make it appear late.

// File: rtl/vli_pkg.sv
package vli_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [3:0] {
        IC_HALT  = 4'h0,
        IC_NOP   = 4'h1,
        IC_CMOV  = 4'h2,
        IC_IRMOV = 4'h3,
        IC_RMMOV = 4'h4,
        IC_MRMOV = 4'h5,
        IC_ALU   = 4'h6,
        IC_JMP   = 4'h7,
        IC_CALL  = 4'h8,
        IC_RET   = 4'h9,
        IC_PUSH  = 4'hA,
        IC_POP   = 4'hB
    } icode_e;

    typedef enum logic [2:0] {
        ST_AOK = 3'd1,
        ST_HLT = 3'd2,
        ST_ADR = 3'd3,
        ST_INS = 3'd4
    } stat_e;

    // where the constant starts inside the window
    typedef enum logic [1:0] {
        CS_NONE = 2'd0,
        CS_AT1  = 2'd1,
        CS_AT2  = 2'd2
    } csel_e;

    localparam logic [NIB_W-1:0] REG_NONE    = 4'hF;
    localparam logic [NIB_W-1:0] FN_MAX_ALU  = 4'd3;
    localparam logic [NIB_W-1:0] FN_MAX_COND = 4'd6;

endpackage

// File: rtl/vli_format_map.sv
module vli_format_map
    import vli_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic [NIB_W-1:0] icode_i,
    output logic [LEN_W-1:0] len_o,
    output logic             has_reg_o,
    output csel_e            csel_o
);

    always_comb begin
        len_o     = LEN_W'(1);
        has_reg_o = 1'b0;
        csel_o    = CS_NONE;
        unique case (icode_i)
            IC_HALT, IC_NOP, IC_RET: begin
                len_o = LEN_W'(1);
            end
            IC_CMOV, IC_ALU, IC_PUSH, IC_POP: begin
                len_o     = LEN_W'(2);
                has_reg_o = 1'b1;
            end
            IC_JMP, IC_CALL: begin
                len_o  = LEN_W'(5);
                csel_o = CS_AT1;
            end
            IC_IRMOV, IC_RMMOV, IC_MRMOV: begin
                len_o     = LEN_W'(6);
                has_reg_o = 1'b1;
                csel_o    = CS_AT2;
            end
            default: begin
                len_o = LEN_W'(1);
            end
        endcase
    end

endmodule

// File: rtl/vli_field_pick.sv
module vli_field_pick
    import vli_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int WIN_W  = 48
) (
    input  logic [WIN_W-1:0]  win_i,
    input  logic              has_reg_i,
    input  csel_e             csel_i,
    output logic [NIB_W-1:0]  ra_o,
    output logic [NIB_W-1:0]  rb_o,
    output logic [WORD_W-1:0] valc_o
);

    localparam int WORD_BYTES = WORD_W / 8;

    logic [WORD_W-1:0] const_at1;
    logic [WORD_W-1:0] const_at2;

    // byte j of each candidate constant comes from window byte j+1 or j+2
    for (genvar j = 0; j < WORD_BYTES; j++) begin : g_const_byte
        assign const_at1[8*j +: 8] = win_i[8*(j+1) +: 8];
        assign const_at2[8*j +: 8] = win_i[8*(j+2) +: 8];
    end

    always_comb begin
        if (has_reg_i) begin
            ra_o = win_i[15:12];
            rb_o = win_i[11:8];
        end else begin
            ra_o = REG_NONE;
            rb_o = REG_NONE;
        end
    end

    always_comb begin
        unique case (csel_i)
            CS_AT1:  valc_o = const_at1;
            CS_AT2:  valc_o = const_at2;
            default: valc_o = '0;
        endcase
    end

endmodule

// File: rtl/vli_status_gen.sv
module vli_status_gen
    import vli_pkg::*;
(
    input  logic [NIB_W-1:0] icode_i,
    input  logic [NIB_W-1:0] ifun_i,
    input  logic             imem_err_i,
    output stat_e            stat_o
);

    logic pair_ok;

    always_comb begin
        unique case (icode_i)
            IC_ALU:           pair_ok = (ifun_i <= FN_MAX_ALU);
            IC_CMOV, IC_JMP:  pair_ok = (ifun_i <= FN_MAX_COND);
            IC_HALT, IC_NOP, IC_IRMOV, IC_RMMOV, IC_MRMOV,
            IC_CALL, IC_RET, IC_PUSH, IC_POP:
                              pair_ok = (ifun_i == '0);
            default:          pair_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (imem_err_i)
            stat_o = ST_ADR;
        else if (!pair_ok)
            stat_o = ST_INS;
        else if (icode_i == IC_HALT)
            stat_o = ST_HLT;
        else
            stat_o = ST_AOK;
    end

endmodule

// File: rtl/vli_decoder.sv
module vli_decoder
    import vli_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    localparam int WIN_BYTES = 2 + WORD_W / 8,
    localparam int WIN_W     = 8 * WIN_BYTES,
    localparam int LEN_W     = $clog2(WIN_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [WIN_W-1:0]  win_i,
    input  logic              imem_err_i,
    output logic [NIB_W-1:0]  icode_o,
    output logic [NIB_W-1:0]  ifun_o,
    output logic [NIB_W-1:0]  ra_o,
    output logic [NIB_W-1:0]  rb_o,
    output logic [WORD_W-1:0] valc_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [ADDR_W-1:0] valp_o,
    output logic [2:0]        stat_o,
    output logic              stop_o
);

    logic [NIB_W-1:0]  icode_c;
    logic [NIB_W-1:0]  ifun_c;
    logic [LEN_W-1:0]  len_c;
    logic              has_reg_c;
    csel_e             csel_c;
    logic [NIB_W-1:0]  ra_c;
    logic [NIB_W-1:0]  rb_c;
    logic [WORD_W-1:0] valc_c;
    stat_e             stat_c;
    logic [ADDR_W-1:0] valp_c;

    assign icode_c = win_i[7:4];
    assign ifun_c  = win_i[3:0];

    vli_format_map #(
        .LEN_W (LEN_W)
    ) u_map (
        .icode_i   (icode_c),
        .len_o     (len_c),
        .has_reg_o (has_reg_c),
        .csel_o    (csel_c)
    );

    vli_field_pick #(
        .WORD_W (WORD_W),
        .WIN_W  (WIN_W)
    ) u_pick (
        .win_i     (win_i),
        .has_reg_i (has_reg_c),
        .csel_i    (csel_c),
        .ra_o      (ra_c),
        .rb_o      (rb_c),
        .valc_o    (valc_c)
    );

    vli_status_gen u_stat (
        .icode_i    (icode_c),
        .ifun_i     (ifun_c),
        .imem_err_i (imem_err_i),
        .stat_o     (stat_c)
    );

    assign valp_c = pc_i + ADDR_W'(len_c);

    // output register: RESET while rst_n is low, DECODE afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icode_o <= '0;
            ifun_o  <= '0;
            ra_o    <= '0;
            rb_o    <= '0;
            valc_o  <= '0;
            len_o   <= '0;
            valp_o  <= '0;
            stat_o  <= 3'(ST_AOK);
            stop_o  <= 1'b0;
        end else begin
            icode_o <= icode_c;
            ifun_o  <= ifun_c;
            ra_o    <= ra_c;
            rb_o    <= rb_c;
            valc_o  <= valc_c;
            len_o   <= len_c;
            valp_o  <= valp_c;
            stat_o  <= 3'(stat_c);
            stop_o  <= (stat_c != ST_AOK);
        end
    end

    // R10
    adr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imem_err_i |=> (stat_o == 3'(ST_ADR)) && stop_o);

    // R8
    high_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_i[7:4] >= 4'hC) && !imem_err_i |=> (stat_o == 3'(ST_INS)));

    // R9
    halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_i[7:0] == 8'h00) && !imem_err_i |=> (stat_o == 3'(ST_HLT)) && stop_o);

    // R3
    len_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (stat_o == 3'(ST_ADR)) || (stat_o == 3'(ST_INS)) ||
                  (len_o == LEN_W'(1)) || (len_o == LEN_W'(2)) ||
                  (len_o == LEN_W'(5)) || (len_o == LEN_W'(6)));

    // R6
    next_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (stat_o == 3'(ST_ADR)) || (stat_o == 3'(ST_INS)) ||
                  (valp_o == $past(pc_i) + ADDR_W'(len_o)));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (icode_o == $past(win_i[7:4])) && (ifun_o == $past(win_i[3:0])));

endmodule

// File: tb/vli_decoder_bench.sv
module vli_decoder_bench;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [47:0] win_i = '0;
    logic        imem_err_i = 1'b0;
    logic [3:0]  icode_o, ifun_o, ra_o, rb_o;
    logic [31:0] valc_o, valp_o;
    logic [2:0]  len_o, stat_o;
    logic        stop_o;

    always #(PERIOD/2) clk = ~clk;

    vli_decoder u_vli_decoder (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .win_i(win_i),
        .imem_err_i(imem_err_i), .icode_o(icode_o), .ifun_o(ifun_o),
        .ra_o(ra_o), .rb_o(rb_o), .valc_o(valc_o), .len_o(len_o),
        .valp_o(valp_o), .stat_o(stat_o), .stop_o(stop_o)
    );

    typedef struct packed {
        logic [3:0]  ic;
        logic [3:0]  fn;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [31:0] valc;
        logic [2:0]  len;
        logic [31:0] valp;
        logic [2:0]  st;
        logic        stop;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(logic [31:0] pc, logic [47:0] w, logic err);
        exp_t e;
        logic [3:0] ic, fn;
        logic ok;
        ic = w[7:4];
        fn = w[3:0];
        e.ic = ic;
        e.fn = fn;
        case (ic)
            4'h2, 4'h6, 4'hA, 4'hB: e.len = 3'd2;
            4'h7, 4'h8:             e.len = 3'd5;
            4'h3, 4'h4, 4'h5:       e.len = 3'd6;
            default:                e.len = 3'd1;
        endcase
        if (ic inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB}) begin
            e.ra = w[15:12];
            e.rb = w[11:8];
        end else begin
            e.ra = 4'hF;
            e.rb = 4'hF;
        end
        if (ic == 4'h7 || ic == 4'h8)
            e.valc = {w[39:32], w[31:24], w[23:16], w[15:8]};
        else if (ic inside {4'h3, 4'h4, 4'h5})
            e.valc = {w[47:40], w[39:32], w[31:24], w[23:16]};
        else
            e.valc = '0;
        if (ic > 4'hB)                     ok = 0;
        else if (ic == 4'h6)               ok = (fn <= 4'd3);
        else if (ic == 4'h2 || ic == 4'h7) ok = (fn <= 4'd6);
        else                               ok = (fn == 4'd0);
        if (err)           e.st = 3'd3;
        else if (!ok)      e.st = 3'd4;
        else if (ic == 0)  e.st = 3'd2;
        else               e.st = 3'd1;
        e.stop = (e.st != 3'd1);
        e.valp = pc + 32'(e.len);
        return e;
    endfunction

    task automatic drive(string tag, logic [31:0] pc,
                         logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                         logic [7:0] b3, logic [7:0] b4, logic [7:0] b5,
                         logic err);
        @(negedge clk);
        pc_i       = pc;
        win_i      = {b5, b4, b3, b2, b1, b0};
        imem_err_i = err;
        exp_q.push_back(model(pc, {b5, b4, b3, b2, b1, b0}, err));
        tag_q.push_back(tag);
    endtask

    // monitor: one result per edge, compared just after it appears
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "stat", 32'(stat_o), 32'(e.st));
                chk({t, "/R11"}, "stop", 32'(stop_o), 32'(e.stop));
                if (e.st == 3'd1 || e.st == 3'd2) begin
                    chk(t, "icode", 32'(icode_o), 32'(e.ic));
                    chk(t, "len", 32'(len_o), 32'(e.len));
                    chk(t, "valp", valp_o, e.valp);
                end
                if (e.st == 3'd1) begin
                    chk(t, "ifun", 32'(ifun_o), 32'(e.fn));
                    chk(t, "ra", 32'(ra_o), 32'(e.ra));
                    chk(t, "rb", 32'(rb_o), 32'(e.rb));
                    chk(t, "valc", valc_o, e.valc);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "icode", 32'(icode_o), 0);
        chk("R1", "len", 32'(len_o), 0);
        chk("R1", "valp", valp_o, 0);
        chk("R1", "valc", valc_o, 0);
        chk("R1", "stat", 32'(stat_o), 1);
        chk("R1", "stop", 32'(stop_o), 0);
        rst_n = 1'b1;

        drive("R2", 32'h0000_0010, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R5", 32'h0000_0100, 8'h30, 8'h82, 8'hcd, 8'hab, 8'h00, 8'h00, 0);
        drive("R4", 32'h0000_0200, 8'h20, 8'h43, 8'h99, 8'h99, 8'h99, 8'h99, 0);
        drive("R7", 32'h0000_0204, 8'h26, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R7", 32'h0000_0208, 8'h27, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R7", 32'h0000_0300, 8'h63, 8'h67, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R7", 32'h0000_0302, 8'h64, 8'h67, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R5", 32'h0000_0400, 8'h76, 8'h78, 8'h56, 8'h34, 8'h12, 8'hee, 0);
        drive("R7", 32'h0000_0405, 8'h77, 8'h78, 8'h56, 8'h34, 8'h12, 8'h00, 0);
        drive("R5", 32'h0000_0500, 8'h80, 8'h00, 8'h10, 8'h00, 8'h00, 8'h55, 0);
        drive("R3", 32'h0000_0600, 8'h90, 8'h44, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R7", 32'h0000_0601, 8'h91, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R4", 32'h0000_0700, 8'hA0, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R4", 32'h0000_0702, 8'hB0, 8'h3F, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R5", 32'h0000_0800, 8'h40, 8'h64, 8'h1c, 8'h04, 8'h00, 8'h00, 0);
        drive("R5", 32'h0000_0806, 8'h50, 8'h15, 8'hf4, 8'hff, 8'hff, 8'hff, 0);
        drive("R7", 32'h0000_0810, 8'h31, 8'hF2, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R9", 32'h0000_0900, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R7", 32'h0000_0904, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R8", 32'h0000_0a00, 8'hC0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R8", 32'h0000_0a01, 8'hD0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R8", 32'h0000_0a02, 8'hE3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R8", 32'h0000_0a03, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R10", 32'h0000_0b00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1);
        drive("R10", 32'h0000_0b01, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1);
        drive("R10", 32'h0000_0b02, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1);
        drive("R6", 32'hFFFF_FFFE, 8'h30, 8'hF1, 8'h01, 8'h00, 8'h00, 8'h00, 0);
        drive("R6", 32'hFFFF_FFFF, 8'h60, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        // R12: back-to-back decodes with differing formats
        drive("R12", 32'h0000_0c00, 8'h70, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 0);
        drive("R12", 32'h0000_0c05, 8'h62, 8'h23, 8'h00, 8'h00, 8'h00, 8'h00, 0);
        drive("R12", 32'h0000_0c07, 8'h10, 8'hAB, 8'hCD, 8'h00, 8'h00, 8'h00, 0);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule